// File: doc/BRIEF.md
# USB Transmit Bit Serializer with Stuffing and NRZI

This block sits between a USB link controller and the transceiver line drivers. It takes 16-bit transmit words through a valid/ready handshake and holds one word in a staging register while the previous word is shifted out. Each word goes out least significant bit first, low byte before high byte. A separate upper-byte qualifier lets a packet end on a single valid low byte.

A zero is inserted after every run of six consecutive one data bits. The resulting stream is NRZI-encoded onto a single line level, starting from the idle J level. A bit-enable strobe from a shared bit clock paces the output, one line bit per strobe. The same logic therefore serves high-speed (strobe every cycle), full-speed and low-speed rates. When the controller drops its valid signal and every pending bit has gone out, the line returns to idle and a one-cycle completion flag is raised.

Top module: `usb_tx_serializer`

## Requirements
- R1: `tx_ready` is high only while `tx_valid` is high and the staging register is empty. A word is taken on a clock edge where both `tx_valid` and `tx_ready` are high, so `tx_ready` never stays high for two cycles in a row.
- R2: Each word goes out LSB first. Bits 7..0 are sent before bits 15..8. When `tx_validh` is low for a word, only its 8 low bits are sent.
- R3: After six consecutive 1 data bits, a 0 bit is inserted. The run count restarts on any 0, whether data or stuffed. A run may span a word boundary.
- R4: An inserted stuff bit consumes one strobe without consuming a data bit. The next strobe sends the data bit that was pending.
- R5: NRZI coding: a 1 keeps the line level and a 0 inverts it. The first bit of a packet is coded against the J level (`line_out` = 1).
- R6: While transmitting, `line_out` changes only on a clock edge where `bit_en` is high, and at most one bit is sent per strobe.
- R7: When idle, `line_oe` is 0 and `line_out` is 1 (J). After reset the block is idle, with `tx_ready` and `tx_done` at 0.
- R8: Once `tx_valid` is low and every data bit and any pending stuff bit has been sent, `line_oe` falls, `line_out` returns to 1, and `tx_done` is high for exactly one cycle.
- R9: Consecutive words of a packet leave without gaps. The first bit of the next word, or its stuff bit, is sent on the strobe after the last bit of the current word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit time |
| tx_data | input | 16 | Transmit word, low byte sent first |
| tx_valid | input | 1 | Controller has a word; packet is in progress |
| tx_validh | input | 1 | Upper byte of `tx_data` is valid |
| tx_ready | output | 1 | Word is taken on this cycle if `tx_valid` is high |
| line_out | output | 1 | NRZI-coded line level (1 = J) |
| line_oe | output | 1 | Transmitter is driving a packet |
| tx_done | output | 1 | One-cycle pulse when the packet has fully left |

## Verification
A wrong run count or a lost stuff bit shows up at the strobe after the faulty decision. From that strobe on, every later line level of the packet is phase-inverted or shifted, so a strobe-by-strobe comparison catches it at once. A bit pointer that advances during a stuff bit, or a high byte sent when it should be skipped, changes the count of strobes until `tx_done`. A wrong end state shows as `tx_done` arriving while expected levels are still outstanding, or as `line_out` not being back at J one cycle after completion.

// File: rtl/usb_tx_pkg.sv
package usb_tx_pkg;
  localparam logic LINE_J = 1'b1;

  // NRZI: a one keeps the level, a zero inverts it
  function automatic logic nrzi_step(input logic level, input logic bit_v);
    return bit_v ? level : ~level;
  endfunction

  // number of serial bits carried by a word
  function automatic int unsigned word_bits(input int unsigned dw, input logic hi_ok);
    return hi_ok ? dw : dw / 2;
  endfunction
endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_valid,
  input  logic          tx_validh,
  input  logic          take,
  output logic          tx_ready,
  output logic          full,
  output logic [DW-1:0] hold_data,
  output logic          hold_hi
);
  assign tx_ready = tx_valid & ~full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
      hold_hi   <= 1'b0;
    end else if (tx_ready) begin
      full      <= 1'b1;
      hold_data <= tx_data;
      hold_hi   <= tx_validh;
    end else if (take) begin
      full      <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_shift_stuff.sv
module tx_shift_stuff #(
  parameter int unsigned DW        = 16,
  parameter int unsigned STUFF_RUN = 6,
  localparam int unsigned CW       = $clog2(DW + 1),
  localparam int unsigned RW       = $clog2(STUFF_RUN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_en,
  input  logic          sending,
  input  logic          hold_full,
  input  logic [DW-1:0] hold_data,
  input  logic          hold_hi,
  output logic          take,
  output logic          emit,
  output logic          emit_bit,
  output logic          stuff_fire,
  output logic          busy,
  output logic [CW-1:0] bits_left,
  output logic [RW-1:0] run_len
);
  import usb_tx_pkg::*;

  logic [DW-1:0] sreg;
  logic          run_full;
  logic          data_fire;
  logic          last_fire;
  logic [CW-1:0] load_cnt;

  assign run_full   = (run_len == RW'(STUFF_RUN));
  assign stuff_fire = bit_en & sending & run_full;
  assign data_fire  = bit_en & (bits_left != '0) & ~run_full;
  assign last_fire  = data_fire & (bits_left == CW'(1));
  assign take       = hold_full & (((bits_left == '0) & ~stuff_fire) | last_fire);
  assign emit       = stuff_fire | data_fire;
  assign emit_bit   = stuff_fire ? 1'b0 : sreg[0];
  assign busy       = (bits_left != '0) | run_full;
  assign load_cnt   = CW'(word_bits(DW, hold_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      bits_left <= '0;
    end else if (take) begin
      sreg      <= hold_data;
      bits_left <= load_cnt;
    end else if (data_fire) begin
      sreg      <= sreg >> 1;
      bits_left <= bits_left - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_len <= '0;
    else if (!sending)   run_len <= '0;
    else if (stuff_fire) run_len <= '0;
    else if (data_fire)  run_len <= sreg[0] ? run_len + RW'(1) : '0;
  end
endmodule

// File: rtl/tx_nrzi_enc.sv
module tx_nrzi_enc (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic emit,
  input  logic emit_bit,
  input  logic finish,
  output logic line_out,
  output logic line_oe,
  output logic tx_done
);
  import usb_tx_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_out <= LINE_J;
      line_oe  <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (finish) begin
        line_out <= LINE_J;
        line_oe  <= 1'b0;
        tx_done  <= 1'b1;
      end else begin
        if (start) line_oe <= 1'b1;
        if (emit)  line_out <= nrzi_step(line_out, emit_bit);
      end
    end
  end
endmodule

// File: rtl/usb_tx_serializer.sv
module usb_tx_serializer #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned STUFF_RUN = 6,
  localparam int unsigned CW       = $clog2(DATA_W + 1),
  localparam int unsigned RW       = $clog2(STUFF_RUN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  input  logic              tx_validh,
  output logic              tx_ready,
  output logic              line_out,
  output logic              line_oe,
  output logic              tx_done
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              hold_hi;
  logic              take;
  logic              emit;
  logic              emit_bit;
  logic              stuff_fire;
  logic              busy;
  logic [CW-1:0]     bits_left;
  logic [RW-1:0]     run_len;
  logic              start;
  logic              finish;

  assign start  = take & ~line_oe;
  assign finish = line_oe & ~busy & ~hold_full & ~tx_valid;

  tx_hold_reg #(.DW(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_validh(tx_validh), .take(take), .tx_ready(tx_ready),
    .full(hold_full), .hold_data(hold_data), .hold_hi(hold_hi)
  );

  tx_shift_stuff #(.DW(DATA_W), .STUFF_RUN(STUFF_RUN)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sending(line_oe),
    .hold_full(hold_full), .hold_data(hold_data), .hold_hi(hold_hi),
    .take(take), .emit(emit), .emit_bit(emit_bit), .stuff_fire(stuff_fire),
    .busy(busy), .bits_left(bits_left), .run_len(run_len)
  );

  tx_nrzi_enc u_enc (
    .clk(clk), .rst_n(rst_n), .start(start), .emit(emit), .emit_bit(emit_bit),
    .finish(finish), .line_out(line_out), .line_oe(line_oe), .tx_done(tx_done)
  );
endmodule

// File: rtl/usb_tx_checker.sv
module usb_tx_checker #(
  parameter int unsigned CW        = 5,
  parameter int unsigned RW        = 3,
  parameter int unsigned STUFF_RUN = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          line_out,
  input logic          line_oe,
  input logic          tx_done,
  input logic          stuff_fire,
  input logic [CW-1:0] bits_left,
  input logic [RW-1:0] run_len
);
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready); // R1
  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> !tx_ready); // R1
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= RW'(STUFF_RUN)); // R3
  AST_STUFF_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_fire |=> line_out != $past(line_out)); // R3
  AST_STUFF_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_fire |=> $stable(bits_left)); // R4
  AST_NO_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && line_oe) |=> (!line_oe || $stable(line_out))); // R6
  AST_IDLE_J: assert property (@(posedge clk) disable iff (!rst_n)
    !line_oe |-> line_out); // R7
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> (!line_oe && line_out && !tx_valid)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R8
endmodule

bind usb_tx_serializer usb_tx_checker #(.CW(CW), .RW(RW), .STUFF_RUN(STUFF_RUN)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .line_out(line_out), .line_oe(line_oe), .tx_done(tx_done),
  .stuff_fire(stuff_fire), .bits_left(bits_left), .run_len(run_len)
);

// File: tb/test_usb_tx_serializer.sv
`timescale 1ns/1ps
module test_usb_tx_serializer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_en = 1'b0;
  logic [15:0] tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_validh = 1'b0;
  logic        tx_ready, line_out, line_oe, tx_done;

  usb_tx_serializer i_usb_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_validh(tx_validh), .tx_ready(tx_ready),
    .line_out(line_out), .line_oe(line_oe), .tx_done(tx_done)
  );

  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  int period = 1;
  int div = 0;
  int done_cnt = 0;
  bit en_prev = 1'b0;
  bit oe_prev = 1'b0;
  bit exp_q[$];
  logic [15:0] pkt[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // strobe generation and strobe-by-strobe comparison, all at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (en_prev && oe_prev && exp_q.size() > 0) begin
        bit e;
        e = exp_q.pop_front();
        chk(line_out == e, "R2/R3/R4/R5/R6/R9 line level", int'(line_out), int'(e));
      end
      if (tx_done) begin
        chk(exp_q.size() == 0, "R8 done with bits outstanding", exp_q.size(), 0);
        done_cnt++;
      end
      bit_en = (div == 0);
      div = (div + 1 >= period) ? 0 : div + 1;
    end
    en_prev = bit_en;
    oe_prev = line_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // reference: stuffing then NRZI from J, as a list of line levels per strobe
  task automatic build_expect(input bit last_hi);
    int ones = 0;
    bit lvl = 1'b1;
    for (int w = 0; w < pkt.size(); w++) begin
      int nb = (w == pkt.size() - 1 && !last_hi) ? 8 : 16;
      for (int b = 0; b < nb; b++) begin
        bit d = pkt[w][b];
        if (ones == 6) begin
          lvl = ~lvl;
          ones = 0;
          exp_q.push_back(lvl);
        end
        if (d) ones++;
        else begin
          lvl = ~lvl;
          ones = 0;
        end
        exp_q.push_back(lvl);
      end
    end
    if (ones == 6) exp_q.push_back(~lvl);
  endtask

  task automatic send_packet(input int per, input bit last_hi);
    int start_done;
    period = per;
    div = 0;
    build_expect(last_hi);
    start_done = done_cnt;
    for (int w = 0; w < pkt.size(); w++) begin
      @(negedge clk);
      tx_valid  = 1'b1;
      tx_data   = pkt[w];
      tx_validh = (w == pkt.size() - 1) ? last_hi : 1'b1;
      #1;
      while (!tx_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = '0;
    while (done_cnt == start_done) @(negedge clk);
    @(negedge clk);
    #1;
    chk(line_oe == 1'b0, "R7 idle oe", int'(line_oe), 0);
    chk(line_out == 1'b1, "R7 idle J level", int'(line_out), 1);
    chk(tx_ready == 1'b0, "R1 no ready without valid", int'(tx_ready), 0);
    chk(done_cnt == start_done + 1, "R8 single done pulse", done_cnt, start_done + 1);
    pkt.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(line_out == 1'b1, "R7 reset line J", int'(line_out), 1);
    chk(line_oe == 1'b0, "R7 reset oe", int'(line_oe), 0);
    chk(tx_ready == 1'b0, "R7 reset ready", int'(tx_ready), 0);
    chk(tx_done == 1'b0, "R7 reset done", int'(tx_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // high-speed rate, zeros then long one run across words (R3, R9)
    pkt.push_back(16'h0000); pkt.push_back(16'hFFFF); pkt.push_back(16'hFFFF);
    send_packet(1, 1'b1);
    // full-speed-like rate, packet ends on low byte only (R2)
    pkt.push_back(16'h7E3F); pkt.push_back(16'h00FF);
    send_packet(4, 1'b0);
    // odd ending that needs a trailing stuff bit (R3, R8)
    pkt.push_back(16'h1234); pkt.push_back(16'hABFC);
    send_packet(3, 1'b0);
    // low-speed-like rate, mixed patterns (R5)
    pkt.push_back(16'hA5C3); pkt.push_back(16'h1234); pkt.push_back(16'h0F0F);
    send_packet(8, 1'b1);
    // single word of ones (R4)
    pkt.push_back(16'hFFFF);
    send_packet(2, 1'b1);
    // high-speed with run spanning the byte boundary exactly at six (R3)
    pkt.push_back(16'h07E0); pkt.push_back(16'hFC3F);
    send_packet(1, 1'b1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all levels consumed", exp_q.size(), 0);
    finish_run();
  end
endmodule